// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Driver

This block drives a four-digit, common-anode seven-segment display by time-sharing one set of segment lines among the four digits. A free-running refresh counter splits time into four digit slots. In each slot the block decodes one of the four 4-bit input values into a segment pattern and enables that digit's anode. The anode is enabled only during the first quarter of the slot. All anodes stay off for the other three quarters, which leaves a dark gap between digits so that no digit shows a faint copy of its neighbour.

Every 4-bit value produces a readable hexadecimal glyph. Slices of a plain binary counter can therefore be wired straight to the digit inputs. The anode bus and the segment bus leave the block from registers that load on the same clock edge, so the two buses never disagree for part of a cycle. The decimal point is held off. The refresh counter width is a parameter: with the default of 17 bits and a 32 MHz clock, each digit is refreshed at about 244 Hz.

Top module: `segdisp_mux4`

## Requirements
- R1: The refresh counter starts at 0 after reset, advances by one every clock and wraps to 0 after 2^CNT_W counts. Its two top bits, [CNT_W-1:CNT_W-2], choose the slot: 0, 1, 2 and 3 select digit0, digit1, digit2 and digit3.
- R2: During an enabled interval the anode bus (active low) is 1110 for digit0, 1101 for digit1, 1011 for digit2 and 0111 for digit3. At most one anode line is ever low.
- R3: The anode bus is 1111 whenever counter bits [CNT_W-3:CNT_W-4] are not both zero. This blanks all digits for the last three quarters of each slot.
- R4: The segment bus is active low, with bit 0 driving segment a and bit 6 driving segment g. Values 0 to 9 give 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000 and 0010000.
- R5: Values 10 to 15 give hexadecimal glyphs: 0001000 (A), 0000011 (b), 1000110 (C), 0100001 (d), 0000110 (E) and 0001110 (F).
- R6: The segment bus carries the glyph of the slot's digit throughout the slot, including the blanked quarters.
- R7: The decimal-point output is always 1 (off).
- R8: The anode and segment buses are registered. After a clock edge they reflect the counter value and the digit inputs that were present just before that edge.
- R9: A synchronous active-high reset clears the counter, drives the anode bus to 1111 and the segment bus to 1111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digit0 | input | 4 | Value shown in slot 0 |
| digit1 | input | 4 | Value shown in slot 1 |
| digit2 | input | 4 | Value shown in slot 2 |
| digit3 | input | 4 | Value shown in slot 3 |
| anode_n | output | 4 | Digit enables, active low |
| seg_n | output | 7 | Segments g..a, active low |
| dp_n | output | 1 | Decimal point, held high |

## Verification
The hardest situation to reach from the ports is a digit input that changes in the single cycle just before the counter enters an enabled quarter. A second is a full counter wrap while digits keep changing. With the default width, a wrap takes 131072 cycles, so the bench uses a 6-bit counter: each quarter then lasts four cycles and a wrap happens every 64 cycles. Random digit updates on most cycles then land on every slot boundary and quarter boundary. Directed phases add a mid-run reset, a latency probe and a sweep of all sixteen values through each slot.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
    localparam int NDIG  = 4;
    localparam int SEL_W = $clog2(NDIG);

    typedef logic [3:0] nib_t;
    typedef logic [6:0] seg_t;

    localparam seg_t SEG_DARK = 7'b1111111;
endpackage

// File: rtl/segdisp_timing.sv
module segdisp_timing
    import segdisp_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic [SEL_W-1:0] sel,
    output logic             slot_on
);
    localparam int SEL_LSB  = CNT_W - SEL_W;
    localparam int QUAL_LSB = SEL_LSB - 2;

    always_comb begin
        cnt_d   = cnt_q + CNT_W'(1);
        sel     = cnt_q[CNT_W-1:SEL_LSB];
        slot_on = (cnt_q[SEL_LSB-1:QUAL_LSB] == 2'b00);
    end
endmodule

// File: rtl/segdisp_digit_sel.sv
module segdisp_digit_sel
    import segdisp_pkg::*;
(
    input  logic [NDIG-1:0][3:0] digits,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 slot_on,
    output nib_t                 value,
    output logic [NDIG-1:0]      an_n
);
    assign value = digits[sel];

    for (genvar g = 0; g < NDIG; g++) begin : g_anode
        assign an_n[g] = !(slot_on && (sel == SEL_W'(g)));
    end
endmodule

// File: rtl/segdisp_hexdec.sv
module segdisp_hexdec
    import segdisp_pkg::*;
(
    input  nib_t value,
    output seg_t seg_n
);
    always_comb begin
        unique case (value)
            4'h0: seg_n = 7'b1000000;
            4'h1: seg_n = 7'b1111001;
            4'h2: seg_n = 7'b0100100;
            4'h3: seg_n = 7'b0110000;
            4'h4: seg_n = 7'b0011001;
            4'h5: seg_n = 7'b0010010;
            4'h6: seg_n = 7'b0000010;
            4'h7: seg_n = 7'b1111000;
            4'h8: seg_n = 7'b0000000;
            4'h9: seg_n = 7'b0010000;
            4'hA: seg_n = 7'b0001000;
            4'hB: seg_n = 7'b0000011;
            4'hC: seg_n = 7'b1000110;
            4'hD: seg_n = 7'b0100001;
            4'hE: seg_n = 7'b0000110;
            default: seg_n = 7'b0001110;
        endcase
    end
endmodule

// File: rtl/segdisp_mux4.sv
module segdisp_mux4
    import segdisp_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] digit0,
    input  logic [3:0] digit1,
    input  logic [3:0] digit2,
    input  logic [3:0] digit3,
    output logic [3:0] anode_n,
    output logic [6:0] seg_n,
    output logic       dp_n
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NDIG-1:0]  an;
        seg_t             seg;
    } state_t;

    state_t st_d, st_q;

    logic [NDIG-1:0][3:0] digits;
    logic [CNT_W-1:0]     cnt_next;
    logic [SEL_W-1:0]     sel;
    logic                 slot_on;
    nib_t                 cur_val;
    logic [NDIG-1:0]      an_next;
    seg_t                 seg_next;
    logic [CNT_W-1:0]     cnt_q;

    assign digits = {digit3, digit2, digit1, digit0};
    assign cnt_q  = st_q.cnt;

    segdisp_timing #(.CNT_W(CNT_W)) u_timing (
        .cnt_q  (st_q.cnt),
        .cnt_d  (cnt_next),
        .sel    (sel),
        .slot_on(slot_on)
    );

    segdisp_digit_sel u_dsel (
        .digits (digits),
        .sel    (sel),
        .slot_on(slot_on),
        .value  (cur_val),
        .an_n   (an_next)
    );

    segdisp_hexdec u_dec (
        .value(cur_val),
        .seg_n(seg_next)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
            st_d.an  = '1;
            st_d.seg = SEG_DARK;
        end else begin
            st_d.cnt = cnt_next;
            st_d.an  = an_next;
            st_d.seg = seg_next;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign anode_n = st_q.an;
    assign seg_n   = st_q.seg;
    assign dp_n    = 1'b1;
endmodule

// File: rtl/segdisp_mux4_chk.sv
module segdisp_mux4_chk #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [3:0]       anode_n,
    input logic [6:0]       seg_n,
    input logic             dp_n
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + CNT_W'(1));

    // R2
    one_anode_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~anode_n));

    // R2
    anode_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (anode_n != 4'hF) |-> (~anode_n == (4'b0001 << $past(cnt[CNT_W-1:CNT_W-2]))));

    // R3
    blank_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt[CNT_W-3:CNT_W-4]) != 2'b00) |-> anode_n == 4'hF);

    // R7
    dp_off_chk: assert property (@(posedge clk) dp_n == 1'b1);

    // R9
    reset_dark_chk: assert property (@(posedge clk)
        rst |=> (anode_n == 4'hF && seg_n == 7'h7F && cnt == '0));
endmodule

bind segdisp_mux4 segdisp_mux4_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt_q),
    .anode_n(anode_n),
    .seg_n  (seg_n),
    .dp_n   (dp_n)
);

// File: tb/segdisp_mux4_bench.sv
module segdisp_mux4_bench;
    localparam int CW = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
    logic [3:0] anode_n;
    logic [6:0] seg_n;
    logic       dp_n;

    int n_chk = 0, n_fail = 0;
    int nc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    segdisp_mux4 #(.CNT_W(CW)) u_segdisp_mux4 (
        .clk(clk), .rst(rst),
        .digit0(d0), .digit1(d1), .digit2(d2), .digit3(d3),
        .anode_n(anode_n), .seg_n(seg_n), .dp_n(dp_n)
    );

    function automatic logic [6:0] glyph(input logic [3:0] v);
        case (v)
            4'd0: return 7'b1000000;  4'd1: return 7'b1111001;
            4'd2: return 7'b0100100;  4'd3: return 7'b0110000;
            4'd4: return 7'b0011001;  4'd5: return 7'b0010010;
            4'd6: return 7'b0000010;  4'd7: return 7'b1111000;
            4'd8: return 7'b0000000;  4'd9: return 7'b0010000;
            4'd10: return 7'b0001000; 4'd11: return 7'b0000011;
            4'd12: return 7'b1000110; 4'd13: return 7'b0100001;
            4'd14: return 7'b0000110; default: return 7'b0001110;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One clock: digits already driven; compare against model, advance model.
    task automatic step();
        logic [3:0] dv [4];
        logic [1:0] s;
        logic [1:0] q;
        logic [3:0] ea;
        logic [3:0] v;
        dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
        s  = nc[CW-1 -: 2];
        q  = nc[CW-3 -: 2];
        v  = dv[s];
        ea = (q == 2'b00) ? ~(4'b0001 << s) : 4'hF;
        @(negedge clk);
        if (nc == 0)         check("R1", {28'd0, anode_n}, {28'd0, ea});
        else if (q == 2'b00) check("R2", {28'd0, anode_n}, {28'd0, ea});
        else                 check("R3", {28'd0, anode_n}, {28'd0, ea});
        if (q != 2'b00)      check("R6", {25'd0, seg_n}, {25'd0, glyph(v)});
        else if (v < 4'd10)  check("R4", {25'd0, seg_n}, {25'd0, glyph(v)});
        else                 check("R5", {25'd0, seg_n}, {25'd0, glyph(v)});
        check("R7", {31'd0, dp_n}, 32'd1);
        nc = (nc + 1) % (1 << CW);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9", {28'd0, anode_n}, 32'hF);
        check("R9", {25'd0, seg_n}, 32'h7F);
        rst = 1'b0;
        nc  = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R8: digit change just before first enabled edge shows one edge later
        d0 = 4'hA;
        step();
        check("R8", {25'd0, seg_n}, {25'd0, glyph(4'hA)});
        d0 = 4'h3;
        step();
        check("R8", {25'd0, seg_n}, {25'd0, glyph(4'h3)});

        // Sweep all sixteen values through every slot
        for (int k = 0; k < 16; k++) begin
            d0 = 4'(k); d1 = 4'(k + 1); d2 = 4'(k + 2); d3 = 4'(k + 3);
            for (int c = 0; c < 64; c++) step();
        end

        // R9: reset mid-run
        for (int c = 0; c < 23; c++) step();
        do_reset();
        for (int c = 0; c < 70; c++) step();

        // Random digits, changing on most cycles
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(3) != 0) begin
                d0 = 4'($urandom); d1 = 4'($urandom);
                d2 = 4'($urandom); d3 = 4'($urandom);
            end
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule